// File: doc/BRIEF.md
# Arithmetic and Logic Flag Unit

This block computes the arithmetic and logic results of an 8-bit processor datapath. It also produces the processor's eight-bit condition byte. That byte includes the two rarely documented bits in positions 5 and 3, which copy bits of an operation-specific byte.

The result and the next flag values are combinational. The flag byte is held in a register that updates on a clock edge in which `op_valid` is high. The carry input of the ADC and SBC operations comes from the stored carry flag.

The condition byte can be loaded as a whole through `flag_load`/`flag_wdata` and is always readable on `flags_q`. Most operations work on bytes. ADD, ADC, SUB and SBC also run on 16-bit operands when `wide` is high. The bit test reads either a register or an indexed address, base plus signed displacement, which feeds the undocumented bits.

Top module: `flagalu_core`

## Requirements
- R1: After reset `flags_q` reads 0x00. While neither `op_valid` nor `flag_load` is high at a rising edge, `flags_q` keeps its value whatever the other inputs do.
- R2: The flag byte is S=bit7, Z=bit6, bit5, H=bit4, bit3, P/V=bit2, N=bit1, C=bit0. With `flag_load` high at a rising edge, `flags_q` takes `flag_wdata` in all eight bits. This includes bits 5 and 3, and a load in the same cycle as `op_valid` wins.
- R3: Byte ADD (op 0), ADC (1), SUB (2) and SBC (3) behave as follows when `wide`=0.
  - The result is the low byte of A±B±cin, zero-extended, where cin is the stored C for ADC/SBC and 0 otherwise.
  - C is the carry or borrow out of bit 7, and H is the carry or borrow out of bit 3.
  - P/V is signed overflow, Z means the byte is zero, and S is bit 7.
  - N is 0 for ADD/ADC and 1 for SUB/SBC.
  - Bits 5 and 3 copy the result.
- R4: 16-bit ADD (op 0, `wide`=1) behaves as follows.
  - The 16-bit sum is the result, C is the carry out of bit 15, H is the carry out of bit 11, and N=0.
  - Bits 5 and 3 copy bits 13 and 11 of the sum.
  - S, Z and P/V keep their stored values.
- R5: 16-bit ADC, SUB and SBC (`wide`=1) set C, H (out of bit 11), N and bits 5/3 as in R4. In addition, S is bit 15, Z means the whole 16-bit result is zero, and P/V is 16-bit signed overflow.
- R6: AND (4), OR (5) and XOR (6) behave as follows, ignoring `wide`.
  - They operate on the low bytes, and the result is the zero-extended byte.
  - C=0 and N=0. H=1 for AND and H=0 for OR and XOR.
  - P/V=1 when the result has an even number of ones.
  - S and Z come from the result byte, and bits 5/3 copy the result.
- R7: CP (7) sets S, Z, H, P/V, N=1 and C as a byte SUB would. The result output is A's low byte unchanged, and bits 5 and 3 copy B's low byte rather than the difference.
- R8: NEG (8) behaves as follows.
  - The result is 0 minus A's low byte, with N=1.
  - C=1 exactly when A is nonzero, and P/V=1 exactly when A is 0x80.
  - H is the borrow out of bit 3, S and Z come from the result, and bits 5/3 copy the result.
- R9: BIT (9) with `bit_indexed`=0 tests bit `bit_sel` of B's low byte.
  - Z=P/V=1 when that bit is clear.
  - S=1 only when bit 7 is selected and set.
  - H=1, N=0, and C is kept.
  - Bits 5/3 copy B's low byte, and the result is A's low byte.
- R10: BIT with `bit_indexed`=1 sets S, Z, P/V, H, N and C as in R9. Bits 5 and 3 copy the high byte of `idx_base` plus `idx_disp` sign-extended to 16 bits.
- R11: Op codes 10 to 15 give a zero result and leave the flag byte unchanged even with `op_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Commit the computed flags at this edge |
| op_code | input | 4 | Operation select (0..9 defined) |
| wide | input | 1 | 16-bit mode for ADD/ADC/SUB/SBC |
| opnd_a | input | 16 | Accumulator operand |
| opnd_b | input | 16 | Source operand |
| bit_sel | input | 3 | Bit index for BIT |
| bit_indexed | input | 1 | BIT source for bits 5/3 is the indexed address |
| idx_base | input | 16 | Index register value for BIT |
| idx_disp | input | 8 | Signed displacement for BIT |
| flag_load | input | 1 | Load the whole flag byte |
| flag_wdata | input | 8 | Flag byte to load |
| result | output | 16 | Operation result |
| flags_q | output | 8 | Stored flag byte |

## Verification
Several properties are checked on every clock cycle:
- The flag byte holds when neither strobe is high, and a load overrides an operation.
- Subtract-type operations always leave N set, and logic operations always leave C clear.
- BIT forces H high and N low.
- 16-bit ADD preserves S, Z and P/V.

The exact arithmetic, which covers result bytes, half-carry, overflow, parity and the source of bits 5 and 3 for each operation, is shown only by the bench's scenarios. These compare every result and every committed flag byte against an independent model. The corner cases among them include compare with a source that differs from the difference, negation of 0x00 and 0x80, and an indexed address whose displacement borrows from the high byte.

// File: rtl/flagalu_pkg.sv
package flagalu_pkg;

    localparam int OP_W   = 4;
    localparam int FLAG_W = 8;

    // flag byte bit positions (fixed by the condition byte layout)
    localparam int FB_C  = 0;
    localparam int FB_N  = 1;
    localparam int FB_PV = 2;
    localparam int FB_X3 = 3;
    localparam int FB_H  = 4;
    localparam int FB_X5 = 5;
    localparam int FB_Z  = 6;
    localparam int FB_S  = 7;

    localparam logic [FLAG_W-1:0] XY_MASK = (FLAG_W'(1) << FB_X5) | (FLAG_W'(1) << FB_X3);

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_CP  = 4'd7,
        OP_NEG = 4'd8,
        OP_BIT = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic pv;
        logic n;
        logic c;
    } core_flags_t;

endpackage

// File: rtl/flagalu_addsub.sv
module flagalu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cy,
    output logic         hc,
    output logic         ov
);
    localparam int HB = W - 4;   // bit above the low nibble of the top byte

    logic [W-1:0] b_eff;
    logic [W:0]   ext;

    // subtraction as a + ~b + ~cin; the carry out is then the inverse of borrow
    assign b_eff = sub ? ~b : b;
    assign ext   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin ^ sub};
    assign sum   = ext[W-1:0];
    assign cy    = ext[W] ^ sub;
    assign hc    = a[HB] ^ b[HB] ^ sum[HB];

    always_comb begin
        if (sub) begin
            ov = (a[W-1] != b[W-1]) && (sum[W-1] != a[W-1]);
        end else begin
            ov = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
        end
    end

endmodule

// File: rtl/flagalu_logic.sv
module flagalu_logic
    import flagalu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_sel_e   sel,
    output logic [W-1:0] res,
    output logic         par_even
);
    always_comb begin
        unique case (sel)
            LG_AND:  res = a & b;
            LG_OR:   res = a | b;
            LG_XOR:  res = a ^ b;
            default: res = '0;
        endcase
    end

    assign par_even = ~^res;

endmodule

// File: rtl/flagalu_bittest.sv
module flagalu_bittest #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16,
    parameter int SEL_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] reg_val,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic              indexed,
    input  logic [ADDR_W-1:0] base,
    input  logic [DATA_W-1:0] disp,
    output logic              bit_clear,
    output logic              sign_hit,
    output logic [DATA_W-1:0] xy_src
);
    localparam int EXT_W = ADDR_W - DATA_W;

    logic              tested;
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] eff_addr;
    logic              unused_addr_lo;

    assign tested    = reg_val[bit_sel];
    assign bit_clear = ~tested;
    assign sign_hit  = tested && (bit_sel == SEL_W'(DATA_W - 1));

    generate
        if (EXT_W > 0) begin : g_sext
            assign disp_ext = {{EXT_W{disp[DATA_W-1]}}, disp};
        end else begin : g_nosext
            assign disp_ext = disp[ADDR_W-1:0];
        end
    endgenerate

    assign eff_addr       = base + disp_ext;
    assign unused_addr_lo = ^eff_addr[ADDR_W-DATA_W-1:0];
    assign xy_src         = indexed ? eff_addr[ADDR_W-1 -: DATA_W] : reg_val;

endmodule

// File: rtl/flagalu_core.sv
module flagalu_core
    import flagalu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WIDE_W = 16,
    parameter int SEL_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic              wide,
    input  logic [WIDE_W-1:0] opnd_a,
    input  logic [WIDE_W-1:0] opnd_b,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic              bit_indexed,
    input  logic [WIDE_W-1:0] idx_base,
    input  logic [DATA_W-1:0] idx_disp,
    input  logic              flag_load,
    input  logic [FLAG_W-1:0] flag_wdata,
    output logic [WIDE_W-1:0] result,
    output logic [FLAG_W-1:0] flags_q
);
    localparam int PAD_W = WIDE_W - DATA_W;

    alu_op_e     op;
    core_flags_t fl_q, fl_nxt;
    logic [1:0]  xy_q, xy_nxt;          // stored bit5/bit3 only
    logic [FLAG_W-1:0] xy_byte;          // operation-specific source byte
    logic        unused_xy;

    logic              is_neg, is_sub_op, use_carry;
    logic [DATA_W-1:0] n_a, n_b, n_sum;
    logic              n_cy, n_hc, n_ov;
    logic [WIDE_W-1:0] w_sum;
    logic              w_cy, w_hc, w_ov;
    logic [DATA_W-1:0] l_res;
    logic              l_par;
    logic_sel_e        l_sel;
    logic              b_clear, b_sign;
    logic [DATA_W-1:0] b_xy;

    assign op        = alu_op_e'(op_code);
    assign is_neg    = (op == OP_NEG);
    assign is_sub_op = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP) || is_neg;
    assign use_carry = ((op == OP_ADC) || (op == OP_SBC)) && fl_q.c;
    assign n_a       = is_neg ? '0 : opnd_a[DATA_W-1:0];
    assign n_b       = is_neg ? opnd_a[DATA_W-1:0] : opnd_b[DATA_W-1:0];

    always_comb begin
        unique case (op)
            OP_OR:   l_sel = LG_OR;
            OP_XOR:  l_sel = LG_XOR;
            default: l_sel = LG_AND;
        endcase
    end

    flagalu_addsub #(.W(DATA_W)) i_narrow (
        .a(n_a), .b(n_b), .cin(use_carry), .sub(is_sub_op),
        .sum(n_sum), .cy(n_cy), .hc(n_hc), .ov(n_ov)
    );

    flagalu_addsub #(.W(WIDE_W)) i_wide (
        .a(opnd_a), .b(opnd_b), .cin(use_carry), .sub(is_sub_op),
        .sum(w_sum), .cy(w_cy), .hc(w_hc), .ov(w_ov)
    );

    flagalu_logic #(.W(DATA_W)) i_logic (
        .a(opnd_a[DATA_W-1:0]), .b(opnd_b[DATA_W-1:0]), .sel(l_sel),
        .res(l_res), .par_even(l_par)
    );

    flagalu_bittest #(.DATA_W(DATA_W), .ADDR_W(WIDE_W), .SEL_W(SEL_W)) i_bit (
        .reg_val(opnd_b[DATA_W-1:0]), .bit_sel(bit_sel), .indexed(bit_indexed),
        .base(idx_base), .disp(idx_disp),
        .bit_clear(b_clear), .sign_hit(b_sign), .xy_src(b_xy)
    );

    // next flags and result
    always_comb begin
        fl_nxt  = fl_q;
        xy_byte = flags_q;
        result  = '0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                fl_nxt.n = is_sub_op;
                if (wide) begin
                    result   = w_sum;
                    fl_nxt.c = w_cy;
                    fl_nxt.h = w_hc;
                    xy_byte  = w_sum[WIDE_W-1 -: DATA_W];
                    if (op != OP_ADD) begin
                        fl_nxt.s  = w_sum[WIDE_W-1];
                        fl_nxt.z  = (w_sum == '0);
                        fl_nxt.pv = w_ov;
                    end
                end else begin
                    result    = {{PAD_W{1'b0}}, n_sum};
                    fl_nxt.c  = n_cy;
                    fl_nxt.h  = n_hc;
                    fl_nxt.pv = n_ov;
                    fl_nxt.s  = n_sum[DATA_W-1];
                    fl_nxt.z  = (n_sum == '0);
                    xy_byte   = n_sum;
                end
            end
            OP_AND, OP_OR, OP_XOR: begin
                result    = {{PAD_W{1'b0}}, l_res};
                fl_nxt.c  = 1'b0;
                fl_nxt.n  = 1'b0;
                fl_nxt.h  = (op == OP_AND);
                fl_nxt.pv = l_par;
                fl_nxt.s  = l_res[DATA_W-1];
                fl_nxt.z  = (l_res == '0);
                xy_byte   = l_res;
            end
            OP_CP: begin
                result    = {{PAD_W{1'b0}}, opnd_a[DATA_W-1:0]};
                fl_nxt.c  = n_cy;
                fl_nxt.h  = n_hc;
                fl_nxt.pv = n_ov;
                fl_nxt.n  = 1'b1;
                fl_nxt.s  = n_sum[DATA_W-1];
                fl_nxt.z  = (n_sum == '0);
                xy_byte   = opnd_b[DATA_W-1:0];
            end
            OP_NEG: begin
                result    = {{PAD_W{1'b0}}, n_sum};
                fl_nxt.c  = n_cy;
                fl_nxt.h  = n_hc;
                fl_nxt.pv = n_ov;
                fl_nxt.n  = 1'b1;
                fl_nxt.s  = n_sum[DATA_W-1];
                fl_nxt.z  = (n_sum == '0);
                xy_byte   = n_sum;
            end
            OP_BIT: begin
                result    = {{PAD_W{1'b0}}, opnd_a[DATA_W-1:0]};
                fl_nxt.z  = b_clear;
                fl_nxt.pv = b_clear;
                fl_nxt.s  = b_sign;
                fl_nxt.h  = 1'b1;
                fl_nxt.n  = 1'b0;
                xy_byte   = b_xy;
            end
            default: begin
                result = '0;
            end
        endcase
    end

    assign xy_nxt    = {xy_byte[FB_X5], xy_byte[FB_X3]};
    assign unused_xy = ^(xy_byte & ~XY_MASK);

    // flag register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
            xy_q <= '0;
        end else if (flag_load) begin
            fl_q <= '{s: flag_wdata[FB_S], z: flag_wdata[FB_Z], h: flag_wdata[FB_H],
                      pv: flag_wdata[FB_PV], n: flag_wdata[FB_N], c: flag_wdata[FB_C]};
            xy_q <= {flag_wdata[FB_X5], flag_wdata[FB_X3]};
        end else if (op_valid) begin
            fl_q <= fl_nxt;
            xy_q <= xy_nxt;
        end
    end

    assign flags_q[FB_S]  = fl_q.s;
    assign flags_q[FB_Z]  = fl_q.z;
    assign flags_q[FB_X5] = xy_q[1];
    assign flags_q[FB_H]  = fl_q.h;
    assign flags_q[FB_X3] = xy_q[0];
    assign flags_q[FB_PV] = fl_q.pv;
    assign flags_q[FB_N]  = fl_q.n;
    assign flags_q[FB_C]  = fl_q.c;

    // assertions
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !flag_load) |=> $stable(flags_q)); // R1

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_load |=> (flags_q == $past(flag_wdata))); // R2

    AST_SUB_SETS_N: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !flag_load && is_sub_op) |=> flags_q[FB_N]); // R3

    AST_WIDE_ADD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !flag_load && wide && op == OP_ADD)
        |=> (flags_q[FB_S] == $past(flags_q[FB_S])) && (flags_q[FB_Z] == $past(flags_q[FB_Z]))
            && (flags_q[FB_PV] == $past(flags_q[FB_PV]))); // R4

    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !flag_load && (op == OP_AND || op == OP_OR || op == OP_XOR))
        |=> !flags_q[FB_C] && !flags_q[FB_N]); // R6

    AST_BIT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !flag_load && op == OP_BIT)
        |=> flags_q[FB_H] && !flags_q[FB_N] && (flags_q[FB_C] == $past(flags_q[FB_C]))); // R9

endmodule

// File: tb/test_flagalu_core.sv
`timescale 1ns/1ps
module test_flagalu_core;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [3:0]  op_code;
    logic        wide;
    logic [15:0] opnd_a, opnd_b;
    logic [2:0]  bit_sel;
    logic        bit_indexed;
    logic [15:0] idx_base;
    logic [7:0]  idx_disp;
    logic        flag_load;
    logic [7:0]  flag_wdata;
    logic [15:0] result;
    logic [7:0]  flags_q;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_f;

    always #2.5 clk = ~clk;   // 200 MHz

    flagalu_core i_flagalu_core (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .wide(wide),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .bit_sel(bit_sel), .bit_indexed(bit_indexed),
        .idx_base(idx_base), .idx_disp(idx_disp), .flag_load(flag_load),
        .flag_wdata(flag_wdata), .result(result), .flags_q(flags_q)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // {ov, half, carry, result[15:0]}
    function automatic logic [18:0] ref_arith(input int w, input int a, input int b, input int c, input bit sub);
        int mask, hm, half, full, hn, sa, sb, sr;
        logic cy, hh, ov;
        mask = (w == 16) ? 32'hFFFF : 32'hFF;
        hm   = (w == 16) ? 32'hFFF  : 32'hF;
        half = (w == 16) ? 32768 : 128;
        sa = (a >= half) ? a - 2*half : a;
        sb = (b >= half) ? b - 2*half : b;
        if (!sub) begin
            full = a + b + c; hn = (a & hm) + (b & hm) + c; sr = sa + sb + c;
            cy = (full > mask); hh = (hn > hm);
        end else begin
            full = a - b - c; hn = (a & hm) - (b & hm) - c; sr = sa - sb - c;
            cy = (full < 0); hh = (hn < 0);
        end
        ov = (sr >= half) || (sr < -half);
        return {ov, hh, cy, 16'(full & mask)};
    endfunction

    function automatic logic [23:0] model(input logic [3:0] op, input logic wd, input logic [15:0] a,
                                          input logic [15:0] b, input logic [2:0] bs, input logic ix,
                                          input logic [15:0] base, input logic [7:0] disp, input logic [7:0] f);
        logic [15:0] r, ea;
        logic [7:0]  xy, lr;
        logic        s, z, h, pv, n, c, tb;
        logic [18:0] ar;
        int ci;
        s = f[7]; z = f[6]; h = f[4]; pv = f[2]; n = f[1]; c = f[0]; xy = f; r = '0;
        ci = (op == 4'd1 || op == 4'd3) ? int'(f[0]) : 0;
        case (op)
            4'd0, 4'd1, 4'd2, 4'd3: begin
                n = (op >= 4'd2);
                if (wd) begin
                    ar = ref_arith(16, int'(a), int'(b), ci, op >= 4'd2);
                    r = ar[15:0]; c = ar[16]; h = ar[17]; xy = r[15:8];
                    if (op != 4'd0) begin s = r[15]; z = (r == 16'h0); pv = ar[18]; end
                end else begin
                    ar = ref_arith(8, int'(a[7:0]), int'(b[7:0]), ci, op >= 4'd2);
                    r = {8'h00, ar[7:0]}; c = ar[16]; h = ar[17]; pv = ar[18];
                    s = r[7]; z = (r[7:0] == 8'h0); xy = r[7:0];
                end
            end
            4'd4, 4'd5, 4'd6: begin
                lr = (op == 4'd4) ? (a[7:0] & b[7:0]) : (op == 4'd5) ? (a[7:0] | b[7:0]) : (a[7:0] ^ b[7:0]);
                r = {8'h00, lr}; c = 1'b0; n = 1'b0; h = (op == 4'd4); pv = ~^lr;
                s = lr[7]; z = (lr == 8'h0); xy = lr;
            end
            4'd7: begin
                ar = ref_arith(8, int'(a[7:0]), int'(b[7:0]), 0, 1'b1);
                r = {8'h00, a[7:0]}; c = ar[16]; h = ar[17]; pv = ar[18]; n = 1'b1;
                s = ar[7]; z = (ar[7:0] == 8'h0); xy = b[7:0];
            end
            4'd8: begin
                ar = ref_arith(8, 0, int'(a[7:0]), 0, 1'b1);
                r = {8'h00, ar[7:0]}; c = ar[16]; h = ar[17]; pv = ar[18]; n = 1'b1;
                s = ar[7]; z = (ar[7:0] == 8'h0); xy = ar[7:0];
            end
            4'd9: begin
                tb = b[bs];
                z = !tb; pv = !tb; s = tb && (bs == 3'd7); h = 1'b1; n = 1'b0;
                r = {8'h00, a[7:0]};
                ea = base + {{8{disp[7]}}, disp};
                xy = ix ? ea[15:8] : b[7:0];
            end
            default: r = '0;
        endcase
        return {r, s, z, xy[5], h, xy[3], pv, n, c};
    endfunction

    task automatic run_op(input string tag, input logic [3:0] op, input logic wd, input logic [15:0] a,
                          input logic [15:0] b, input logic [2:0] bs, input logic ix,
                          input logic [15:0] base, input logic [7:0] disp);
        logic [23:0] m;
        @(negedge clk);
        op_code = op; wide = wd; opnd_a = a; opnd_b = b; bit_sel = bs; bit_indexed = ix;
        idx_base = base; idx_disp = disp; op_valid = 1'b1;
        #1;
        m = model(op, wd, a, b, bs, ix, base, disp, exp_f);
        check({tag, " result"}, result, m[23:8]);
        @(negedge clk);
        op_valid = 1'b0;
        exp_f = m[7:0];
        #1;
        check({tag, " flags"}, {8'h00, flags_q}, {8'h00, exp_f});
    endtask

    task automatic load_flags(input string tag, input logic [7:0] val, input logic with_op);
        @(negedge clk);
        flag_load = 1'b1; flag_wdata = val; op_valid = with_op; op_code = 4'd0; opnd_a = 16'h00FF; opnd_b = 16'h0001;
        @(negedge clk);
        flag_load = 1'b0; op_valid = 1'b0;
        exp_f = val;
        #1;
        check(tag, {8'h00, flags_q}, {8'h00, exp_f});
    endtask

    function automatic string tag_of(input logic [3:0] op, input logic wd, input logic ix);
        case (op)
            4'd0: return wd ? "R4 add16" : "R3 add8";
            4'd1, 4'd2, 4'd3: return wd ? "R5 arith16" : "R3 arith8";
            4'd4, 4'd5, 4'd6: return "R6 logic";
            4'd7: return "R7 compare";
            4'd8: return "R8 negate";
            4'd9: return ix ? "R10 bit indexed" : "R9 bit register";
            default: return "R11 undefined op";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [3:0] rop;
        logic rwd, rix;
        logic [15:0] ra, rb, rbase;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; op_valid = 1'b0; op_code = '0; wide = 1'b0; opnd_a = '0; opnd_b = '0;
        bit_sel = '0; bit_indexed = 1'b0; idx_base = '0; idx_disp = '0; flag_load = 1'b0; flag_wdata = '0;
        exp_f = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset flags", {8'h00, flags_q}, 16'h0000);

        // directed corner cases
        run_op("R3 add overflow", 4'd0, 1'b0, 16'h007F, 16'h0001, 3'd0, 1'b0, 16'h0, 8'h0);
        check("R3 add flag byte", {8'h00, flags_q}, 16'h0094);
        // R1: idle cycles with changing inputs must not touch the flags
        @(negedge clk);
        op_code = 4'd4; opnd_a = 16'hFFFF; opnd_b = 16'h0000; flag_wdata = 8'hFF;
        repeat (3) @(negedge clk);
        check("R1 idle hold", {8'h00, flags_q}, {8'h00, exp_f});

        load_flags("R2 load all ones", 8'hFF, 1'b0);
        load_flags("R2 load xy only", 8'h28, 1'b0);
        load_flags("R2 load beats op", 8'h41, 1'b1);
        run_op("R3 adc with stored carry", 4'd1, 1'b0, 16'h000F, 16'h0010, 3'd0, 1'b0, 16'h0, 8'h0);
        run_op("R3 sbc borrow", 4'd3, 1'b0, 16'h0000, 16'h0001, 3'd0, 1'b0, 16'h0, 8'h0);

        load_flags("R4 preload", 8'hC4, 1'b0);
        run_op("R4 add16 wrap keeps SZPV", 4'd0, 1'b1, 16'hFFFF, 16'h0001, 3'd0, 1'b0, 16'h0, 8'h0);
        check("R4 add16 flag byte", {8'h00, flags_q}, 16'h00D5);
        load_flags("R5 preload carry", 8'h01, 1'b0);
        run_op("R5 sbc16 overflow", 4'd3, 1'b1, 16'h8000, 16'h0001, 3'd0, 1'b0, 16'h0, 8'h0);
        run_op("R5 sub16 zero", 4'd2, 1'b1, 16'h1234, 16'h1234, 3'd0, 1'b0, 16'h0, 8'h0);

        run_op("R6 and parity", 4'd4, 1'b0, 16'h00F3, 16'h003C, 3'd0, 1'b0, 16'h0, 8'h0);
        run_op("R6 xor zero", 4'd6, 1'b1, 16'hAB5A, 16'h125A, 3'd0, 1'b0, 16'h0, 8'h0);
        run_op("R7 compare xy from source", 4'd7, 1'b0, 16'h0010, 16'h0028, 3'd0, 1'b0, 16'h0, 8'h0);
        run_op("R8 negate 0x80", 4'd8, 1'b0, 16'h0080, 16'h0000, 3'd0, 1'b0, 16'h0, 8'h0);
        run_op("R8 negate zero", 4'd8, 1'b0, 16'h0000, 16'h0000, 3'd0, 1'b0, 16'h0, 8'h0);
        run_op("R9 bit7 set", 4'd9, 1'b0, 16'h0055, 16'h00A8, 3'd7, 1'b0, 16'h0, 8'h0);
        run_op("R9 bit clear", 4'd9, 1'b0, 16'h0055, 16'h00F7, 3'd3, 1'b0, 16'h0, 8'h0);
        run_op("R10 indexed no borrow", 4'd9, 1'b0, 16'h0000, 16'h0001, 3'd0, 1'b1, 16'h2800, 8'h00);
        run_op("R10 indexed borrow", 4'd9, 1'b0, 16'h0000, 16'h0001, 3'd0, 1'b1, 16'h2800, 8'hFF);
        load_flags("R11 preload", 8'hA9, 1'b0);
        run_op("R11 undefined op", 4'd13, 1'b1, 16'h1111, 16'h2222, 3'd0, 1'b0, 16'h0, 8'h0);

        // constrained random
        for (int i = 0; i < 1200; i++) begin
            rop = 4'($urandom_range(0, 11));
            rwd = 1'($urandom_range(0, 1));
            rix = 1'($urandom_range(0, 1));
            ra  = 16'($urandom);
            rb  = ($urandom_range(0, 7) == 0) ? ra : 16'($urandom);
            rbase = 16'($urandom);
            if (i % 16 == 7) begin
                load_flags("R2 random load", 8'($urandom), 1'($urandom_range(0, 1)));
            end
            run_op(tag_of(rop, rwd, rix), rop, rwd, ra, rb, 3'($urandom), rix, rbase, 8'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule